// File: doc/BRIEF.md
# Bus Target Register Port

This block is the slave side of a 32-bit multiplexed address/data bus in the PCI style. It serves a small internal register file. In the first clock of a transaction the shared lines carry an address and a command. The block records both, decodes them over the next clock and, if it accepts the cycle, claims it one clock after that. It then moves one 32-bit word per completed handshake until the initiator signals the final phase.

The shared-line outputs are modelled as value/enable pairs. After reset the block leaves every shared line undriven. It drives the claim line, the target-ready line and, for reads, the data lines only while it owns a cycle. Before letting go of the two control lines it holds them high for one clock. A burst steps through consecutive words of the window. When it passes the top of the window it wraps to the first word.

Top module: `pci_tgt_port`

## Requirements
- R1: After reset, and at any time the block has not claimed a cycle, `claim_oe_o`, `trgt_rdy_oe_o` and `addr_data_oe_o` are all low.
- R2: An address phase is the clock edge at which `cyc_n_i` is first sampled low while the block is idle. If that phase is accepted, then after the next edge `claim_n_o` is low with `claim_oe_o` high, and `trgt_rdy_n_o` is high with `trgt_rdy_oe_o` high.
- R3: Target ready is asserted only after the claim. `trgt_rdy_n_o` goes low one edge after `claim_n_o` went low, and both stay low until the final phase completes, including clocks in which the initiator holds `init_rdy_n_i` high.
- R4: Only these encodings on `cmd_be_n_i` (bit 3 first) are decoded: 0110, 1100 and 1110 as memory reads; 0111 and 1111 as memory writes; 0010 as I/O read; 0011 as I/O write; 1010 and 1011 as configuration read and write. Every other encoding is never claimed. Configuration commands are never claimed.
- R5: A cycle is claimed only when the address lies in [BASE_ADDR, BASE_ADDR+WIN_BYTES) and the command's space matches MEM_SPACE (1 selects memory, 0 selects I/O). Otherwise every shared-line enable stays low, and no register changes.
- R6: A data phase completes only at an edge where `init_rdy_n_i` is sampled low while target ready is asserted. An edge with `init_rdy_n_i` high transfers nothing.
- R7: On a completed write phase, byte lane b (bits 8b+7..8b) of the addressed register takes the value on `addr_data_i` if `cmd_be_n_i[b]` is 0. If that bit is 1, the lane keeps its value.
- R8: During a claimed read, `addr_data_oe_o` is high from the claim clock through the last data clock. In each data clock `addr_data_o` shows the register currently addressed.
- R9: The first register index is (address − BASE_ADDR)/4. After each completed phase the index advances by one, which is 4 bytes, and it wraps from the last word of the window to word 0.
- R10: A completed phase with `cyc_n_i` sampled high is the last one. In the next clock `claim_n_o` and `trgt_rdy_n_o` are driven high with their enables still high. In the clock after that, all enables are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high bus reset |
| addr_data_i | input | 32 | Shared address/data lines as seen by the block |
| addr_data_o | output | 32 | Read data driven onto the shared lines |
| addr_data_oe_o | output | 1 | Enable for `addr_data_o` |
| cmd_be_n_i | input | 4 | Command in the address phase, active-low byte enables afterwards |
| cyc_n_i | input | 1 | Initiator's active-low cycle frame |
| init_rdy_n_i | input | 1 | Initiator ready, active low |
| claim_n_o | output | 1 | Active-low claim (device select) value |
| claim_oe_o | output | 1 | Enable for `claim_n_o` |
| trgt_rdy_n_o | output | 1 | Active-low target ready value |
| trgt_rdy_oe_o | output | 1 | Enable for `trgt_rdy_n_o` |

## Verification
The hardest case to reach is a burst that must wrap inside the window while the initiator inserts wait states. That case combines the index arithmetic, the completion rule and the last-phase detection in one transaction. The stimulus starts write and read bursts two words below the top of the window, holds the initiator's ready line high for the first clocks of the data phase, and then reads the wrapped words back. Rejected cycles are tested the same way. A reserved command, a configuration command, a wrong-space command and out-of-window addresses are sent with write data on the lines, and a later read shows that the register contents are unchanged.

// File: rtl/pci_tgt_pkg.sv
package pci_tgt_pkg;

    // Command encodings as they appear on the command/byte-enable lines
    localparam logic [3:0] CMD_IO_RD       = 4'b0010;
    localparam logic [3:0] CMD_IO_WR       = 4'b0011;
    localparam logic [3:0] CMD_MEM_RD      = 4'b0110;
    localparam logic [3:0] CMD_MEM_WR      = 4'b0111;
    localparam logic [3:0] CMD_CFG_RD      = 4'b1010;
    localparam logic [3:0] CMD_CFG_WR      = 4'b1011;
    localparam logic [3:0] CMD_MEM_RD_MULT = 4'b1100;
    localparam logic [3:0] CMD_MEM_RD_LINE = 4'b1110;
    localparam logic [3:0] CMD_MEM_WR_INV  = 4'b1111;

    typedef enum logic [1:0] {
        SP_NONE = 2'd0,
        SP_MEM  = 2'd1,
        SP_IO   = 2'd2,
        SP_CFG  = 2'd3
    } space_e;

    typedef struct packed {
        logic   valid;
        space_e space;
        logic   is_write;
    } cmd_info_t;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_DECODE = 3'd1,
        ST_CLAIM  = 3'd2,
        ST_DATA   = 3'd3,
        ST_TURN   = 3'd4,
        ST_SKIP   = 3'd5
    } tgt_state_e;

    function automatic cmd_info_t decode_cmd(input logic [3:0] c);
        cmd_info_t r;
        r.valid    = 1'b0;
        r.space    = SP_NONE;
        r.is_write = 1'b0;
        case (c)
            CMD_MEM_RD, CMD_MEM_RD_MULT, CMD_MEM_RD_LINE: begin
                r.valid = 1'b1; r.space = SP_MEM; r.is_write = 1'b0;
            end
            CMD_MEM_WR, CMD_MEM_WR_INV: begin
                r.valid = 1'b1; r.space = SP_MEM; r.is_write = 1'b1;
            end
            CMD_IO_RD: begin
                r.valid = 1'b1; r.space = SP_IO; r.is_write = 1'b0;
            end
            CMD_IO_WR: begin
                r.valid = 1'b1; r.space = SP_IO; r.is_write = 1'b1;
            end
            CMD_CFG_RD: begin
                r.valid = 1'b1; r.space = SP_CFG; r.is_write = 1'b0;
            end
            CMD_CFG_WR: begin
                r.valid = 1'b1; r.space = SP_CFG; r.is_write = 1'b1;
            end
            default: r.valid = 1'b0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/pci_tgt_decode.sv
module pci_tgt_decode
    import pci_tgt_pkg::*;
#(
    parameter logic [31:0] BASE_ADDR = 32'h0001_0000,
    parameter int          WIN_BYTES = 64,
    parameter bit          MEM_SPACE = 1'b1,
    parameter int          IDX_W     = 4,
    parameter int          OFF_W     = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             capture_i,
    input  logic [31:2]      addr_i,
    input  logic [3:0]       cmd_i,
    output logic             hit_o,
    output logic             write_o,
    output logic [IDX_W-1:0] idx_o
);

    cmd_info_t info;
    logic      space_ok;
    logic      win_ok;

    always_comb begin
        info     = decode_cmd(cmd_i);
        space_ok = info.valid &&
                   (MEM_SPACE ? (info.space == SP_MEM) : (info.space == SP_IO));
        win_ok   = (addr_i[31:OFF_W] == BASE_ADDR[31:OFF_W]);
    end

    // Address and command are registered in the address phase; the
    // decision is taken from these registers one clock later.
    always_ff @(posedge clk) begin
        if (rst) begin
            hit_o   <= 1'b0;
            write_o <= 1'b0;
            idx_o   <= '0;
        end else if (capture_i) begin
            hit_o   <= space_ok && win_ok;
            write_o <= info.is_write;
            idx_o   <= addr_i[OFF_W-1:2];
        end
    end

    initial begin
        assert (WIN_BYTES >= 8 && (WIN_BYTES & (WIN_BYTES - 1)) == 0)
            else $error("window size must be a power of two of at least 8 bytes");
    end

endmodule

// File: rtl/pci_tgt_fsm.sv
module pci_tgt_fsm
    import pci_tgt_pkg::*;
#(
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cyc_n_i,
    input  logic             init_rdy_n_i,
    input  logic             hit_i,
    input  logic             write_i,
    input  logic [IDX_W-1:0] start_idx_i,
    output logic             capture_o,
    output logic             wr_en_o,
    output logic [IDX_W-1:0] idx_o,
    output logic             claim_n_o,
    output logic             claim_oe_o,
    output logic             rdy_n_o,
    output logic             rdy_oe_o,
    output logic             ad_oe_o
);

    tgt_state_e state_q, state_d;
    logic       phase_done;

    assign capture_o  = (state_q == ST_IDLE) && !cyc_n_i;
    assign phase_done = (state_q == ST_DATA) && !init_rdy_n_i;
    assign wr_en_o    = phase_done && write_i;

    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_IDLE:   if (!cyc_n_i)                 state_d = ST_DECODE;
            ST_DECODE: state_d = hit_i ? ST_CLAIM : ST_SKIP;
            ST_CLAIM:  state_d = ST_DATA;
            ST_DATA:   if (phase_done && cyc_n_i)    state_d = ST_TURN;
            ST_TURN:   state_d = ST_IDLE;
            ST_SKIP:   if (cyc_n_i && init_rdy_n_i)  state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    // Word index: loaded after decode, advances on each completed phase
    always_ff @(posedge clk) begin
        if (rst)                        idx_o <= '0;
        else if (state_q == ST_DECODE)  idx_o <= start_idx_i;
        else if (phase_done)            idx_o <= idx_o + 1'b1;
    end

    always_comb begin
        claim_oe_o = (state_q == ST_CLAIM) || (state_q == ST_DATA) || (state_q == ST_TURN);
        rdy_oe_o   = claim_oe_o;
        claim_n_o  = !((state_q == ST_CLAIM) || (state_q == ST_DATA));
        rdy_n_o    = !(state_q == ST_DATA);
        ad_oe_o    = !write_i && ((state_q == ST_CLAIM) || (state_q == ST_DATA));
    end

    AST_CLAIM_AFTER_ADDR: assert property (@(posedge clk) disable iff (rst)
        $fell(claim_n_o) |-> ($past(cyc_n_i, 2) == 1'b0)) else $error("claim timing"); // R2

    AST_DRIVE_STARTS_LOW: assert property (@(posedge clk) disable iff (rst)
        $rose(claim_oe_o) |-> (!claim_n_o && rdy_oe_o && rdy_n_o)) else $error("drive start"); // R2

    AST_RDY_AFTER_CLAIM: assert property (@(posedge clk) disable iff (rst)
        $fell(rdy_n_o) |-> $past(!claim_n_o)) else $error("ready before claim"); // R3

    AST_BURST_STEP: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_DATA && !init_rdy_n_i && !cyc_n_i) |=> (idx_o == $past(idx_o) + 1'b1))
        else $error("burst index step"); // R9

    AST_RELEASE_HIGH: assert property (@(posedge clk) disable iff (rst)
        $fell(claim_oe_o) |-> ($past(claim_n_o) && $past(rdy_n_o))) else $error("release"); // R10

endmodule

// File: rtl/pci_tgt_regfile.sv
module pci_tgt_regfile #(
    parameter int NREGS = 16,
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en_i,
    input  logic [IDX_W-1:0] idx_i,
    input  logic [31:0]      wdata_i,
    input  logic [3:0]       be_n_i,
    output logic [31:0]      rdata_o
);

    for (genvar b = 0; b < 4; b++) begin : g_lane
        logic [7:0] lane_q [NREGS];

        always_ff @(posedge clk) begin
            if (rst) begin
                for (int i = 0; i < NREGS; i++) lane_q[i] <= 8'h00;
            end else if (wr_en_i && !be_n_i[b]) begin
                lane_q[idx_i] <= wdata_i[8*b +: 8];
            end
        end

        assign rdata_o[8*b +: 8] = lane_q[idx_i];
    end

endmodule

// File: rtl/pci_tgt_port.sv
module pci_tgt_port
    import pci_tgt_pkg::*;
#(
    parameter logic [31:0] BASE_ADDR = 32'h0001_0000,
    parameter int          WIN_BYTES = 64,
    parameter bit          MEM_SPACE = 1'b1
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [31:0] addr_data_i,
    output logic [31:0] addr_data_o,
    output logic        addr_data_oe_o,
    input  logic [3:0]  cmd_be_n_i,
    input  logic        cyc_n_i,
    input  logic        init_rdy_n_i,
    output logic        claim_n_o,
    output logic        claim_oe_o,
    output logic        trgt_rdy_n_o,
    output logic        trgt_rdy_oe_o
);

    localparam int NREGS = WIN_BYTES / 4;
    localparam int IDX_W = $clog2(NREGS);
    localparam int OFF_W = $clog2(WIN_BYTES);

    logic             capture;
    logic             hit_q;
    logic             write_q;
    logic [IDX_W-1:0] start_idx;
    logic [IDX_W-1:0] cur_idx;
    logic             wr_en;

    pci_tgt_decode #(
        .BASE_ADDR (BASE_ADDR),
        .WIN_BYTES (WIN_BYTES),
        .MEM_SPACE (MEM_SPACE),
        .IDX_W     (IDX_W),
        .OFF_W     (OFF_W)
    ) u_decode (
        .clk       (clk),
        .rst       (rst),
        .capture_i (capture),
        .addr_i    (addr_data_i[31:2]),
        .cmd_i     (cmd_be_n_i),
        .hit_o     (hit_q),
        .write_o   (write_q),
        .idx_o     (start_idx)
    );

    pci_tgt_fsm #(
        .IDX_W (IDX_W)
    ) u_fsm (
        .clk          (clk),
        .rst          (rst),
        .cyc_n_i      (cyc_n_i),
        .init_rdy_n_i (init_rdy_n_i),
        .hit_i        (hit_q),
        .write_i      (write_q),
        .start_idx_i  (start_idx),
        .capture_o    (capture),
        .wr_en_o      (wr_en),
        .idx_o        (cur_idx),
        .claim_n_o    (claim_n_o),
        .claim_oe_o   (claim_oe_o),
        .rdy_n_o      (trgt_rdy_n_o),
        .rdy_oe_o     (trgt_rdy_oe_o),
        .ad_oe_o      (addr_data_oe_o)
    );

    pci_tgt_regfile #(
        .NREGS (NREGS),
        .IDX_W (IDX_W)
    ) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en_i (wr_en),
        .idx_i   (cur_idx),
        .wdata_i (addr_data_i),
        .be_n_i  (cmd_be_n_i),
        .rdata_o (addr_data_o)
    );

    AST_WRITE_ON_HANDSHAKE: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> (!claim_n_o && !trgt_rdy_n_o && !init_rdy_n_i)) else $error("write w/o handshake"); // R6

    AST_QUIET_WHEN_UNDRIVEN: assert property (@(posedge clk) disable iff (rst)
        !claim_oe_o |-> !addr_data_oe_o) else $error("data driven without claim"); // R1

endmodule

// File: tb/sim_pci_tgt_port.sv
`timescale 1ns/1ps
module sim_pci_tgt_port;

    localparam logic [31:0] BASE = 32'h0001_0000;
    localparam int          NW   = 16;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] ad_i = '0;
    logic [31:0] ad_o;
    logic        ad_oe;
    logic [3:0]  cbe_n = 4'hF;
    logic        cyc_n = 1'b1;
    logic        irdy_n = 1'b1;
    logic        clm_n, clm_oe, rdy_n, rdy_oe;

    int n_chk = 0;
    int n_err = 0;
    logic [31:0] model [NW];

    always #4 clk = ~clk;

    pci_tgt_port #(.BASE_ADDR(BASE), .WIN_BYTES(64), .MEM_SPACE(1'b1)) u0 (
        .clk(clk), .rst(rst),
        .addr_data_i(ad_i), .addr_data_o(ad_o), .addr_data_oe_o(ad_oe),
        .cmd_be_n_i(cbe_n), .cyc_n_i(cyc_n), .init_rdy_n_i(irdy_n),
        .claim_n_o(clm_n), .claim_oe_o(clm_oe),
        .trgt_rdy_n_o(rdy_n), .trgt_rdy_oe_o(rdy_oe)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    // One clock of the reference model: compare outputs at the falling edge
    task automatic step(input logic e_drv, input logic e_clm, input logic e_rdy,
                        input logic e_adoe, input string tag);
        @(negedge clk);
        chk({tag, " claim_oe"}, {31'd0, clm_oe}, {31'd0, e_drv});
        chk({tag, " rdy_oe"},   {31'd0, rdy_oe}, {31'd0, e_drv});
        chk({tag, " ad_oe"},    {31'd0, ad_oe},  {31'd0, e_adoe});
        if (e_drv) begin
            chk({tag, " claim_n"}, {31'd0, clm_n}, {31'd0, e_clm});
            chk({tag, " rdy_n"},   {31'd0, rdy_n}, {31'd0, e_rdy});
        end
    endtask

    task automatic txn(input logic [31:0] addr, input logic [3:0] cmd, input int n,
                       input int waits, input logic [3:0] be_n, input logic hit,
                       input logic is_wr, input logic [31:0] seed);
        int idx;
        int i;
        int w;
        logic [31:0] d;
        step(1'b0, 1'b1, 1'b1, 1'b0, "R1 idle");
        cyc_n = 1'b0; ad_i = addr; cbe_n = cmd; irdy_n = 1'b1;
        step(1'b0, 1'b1, 1'b1, 1'b0, "R2 decode clock");
        ad_i = is_wr ? seed : 32'd0; cbe_n = be_n; irdy_n = 1'b0; cyc_n = (n == 1);
        if (!hit) begin
            cyc_n = 1'b1;
            step(1'b0, 1'b1, 1'b1, 1'b0, "R4/R5 not claimed");
            step(1'b0, 1'b1, 1'b1, 1'b0, "R4/R5 not claimed");
            irdy_n = 1'b1;
            step(1'b0, 1'b1, 1'b1, 1'b0, "R5 still quiet");
            return;
        end
        step(1'b1, 1'b0, 1'b1, !is_wr, "R2 claim");
        irdy_n = (waits > 0);
        idx = ((addr - BASE) >> 2) % NW;
        i = 0;
        w = waits;
        while (i < n) begin
            step(1'b1, 1'b0, 1'b0, !is_wr, "R3 ready");
            if (!is_wr) chk("R8/R9 read data", ad_o, model[idx]);
            if (w > 0) begin
                irdy_n = 1'b1;
                w--;
            end else begin
                d = seed + i * 32'h0101_0101;
                irdy_n = 1'b0;
                cyc_n = (i == n - 1);
                ad_i = is_wr ? d : 32'd0;
                cbe_n = be_n;
                if (is_wr)
                    for (int b = 0; b < 4; b++)
                        if (!be_n[b]) model[idx][8*b +: 8] = d[8*b +: 8];
                idx = (idx + 1) % NW;
                i++;
            end
        end
        step(1'b1, 1'b1, 1'b1, 1'b0, "R10 turnaround");
        irdy_n = 1'b1; cyc_n = 1'b1; cbe_n = 4'hF;
        step(1'b0, 1'b1, 1'b1, 1'b0, "R10 released");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog (R10 completion) actual hung expected finished");
        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        for (int k = 0; k < NW; k++) model[k] = 32'd0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        step(1'b0, 1'b1, 1'b1, 1'b0, "R1 after reset");
        step(1'b0, 1'b1, 1'b1, 1'b0, "R1 after reset");

        // R7 full-word write then read back (R8)
        txn(BASE + 8,  4'b0111, 1, 0, 4'b0000, 1'b1, 1'b1, 32'hA5A5_0001);
        txn(BASE + 8,  4'b0110, 1, 0, 4'b0000, 1'b1, 1'b0, 32'd0);
        // R7 partial byte enables, read back with read-line
        txn(BASE + 12, 4'b0111, 1, 0, 4'b1010, 1'b1, 1'b1, 32'h1122_3344);
        txn(BASE + 12, 4'b1110, 1, 0, 4'b0000, 1'b1, 1'b0, 32'd0);
        // R6/R9 burst across the window top with initiator wait states
        txn(BASE + 56, 4'b0111, 4, 2, 4'b0000, 1'b1, 1'b1, 32'hC0DE_0010);
        txn(BASE + 56, 4'b1100, 4, 1, 4'b0000, 1'b1, 1'b0, 32'd0);
        // R4 reserved and configuration commands, R5 wrong space / outside window
        txn(BASE + 0,  4'b0100, 1, 0, 4'b0000, 1'b0, 1'b1, 32'hDEAD_0001);
        txn(BASE + 0,  4'b0001, 1, 0, 4'b0000, 1'b0, 1'b1, 32'hDEAD_0002);
        txn(BASE + 0,  4'b1011, 1, 0, 4'b0000, 1'b0, 1'b1, 32'hDEAD_0003);
        txn(BASE + 0,  4'b0011, 1, 0, 4'b0000, 1'b0, 1'b1, 32'hDEAD_0004);
        txn(BASE + 64, 4'b0111, 1, 0, 4'b0000, 1'b0, 1'b1, 32'hDEAD_0005);
        txn(BASE - 4,  4'b0111, 1, 0, 4'b0000, 1'b0, 1'b1, 32'hDEAD_0006);
        // R5 registers untouched: word 0 holds burst data, word 15 too
        txn(BASE + 0,  4'b0110, 1, 0, 4'b0000, 1'b1, 1'b0, 32'd0);
        txn(BASE + 60, 4'b0110, 1, 0, 4'b0000, 1'b1, 1'b0, 32'd0);
        // R4 write-and-invalidate is decoded as a memory write
        txn(BASE + 20, 4'b1111, 2, 0, 4'b0000, 1'b1, 1'b1, 32'h5500_AA00);
        txn(BASE + 20, 4'b0110, 2, 3, 4'b0000, 1'b1, 1'b0, 32'd0);
        step(1'b0, 1'b1, 1'b1, 1'b0, "R1 final idle");

        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

endmodule